// File: doc/BRIEF.md
# Tiered Round-Robin Wormhole Output Allocator

This block decides which source may drive one output port of a packet router that forwards wormhole packets. Every cycle the output is free, it looks at the request lines from all sources and picks one winner. Sources fall into three fixed tiers. The shared down-going buffers come first. Inputs arriving from higher in the tree come second, and inputs arriving from lower in the tree come last. Within the highest tier that has any request, the winner is chosen in round-robin order.

Once a source wins, the output stays locked to it for the whole packet, however many flits that is. The lock ends when that source's trailer flit passes. The block then spends one cycle idle and arbitrates again on the next cycle. Sources are packed into the request, trailer and grant vectors in tier order, and the sizes of the three tiers are parameters.

Top module: `wh_out_alloc`

## Requirements
- R1: After reset, every grant bit is low and `busy` is low.
- R2: While the output is free and no request line is high, the output stays free: `grant` is all zero and `busy` is low.
- R3: When the output is free and at least one request is high at a clock edge, from the next cycle on `grant` has exactly one bit set, that bit belongs to a source that was requesting, and `busy` is high.
- R4: Source bit positions are: shared buffers at `[N_SHR-1:0]`, upper inputs at the next `N_UP` bits, and lower inputs at the top `N_DOWN` bits. A request from any shared buffer beats every upper and lower request.
- R5: When no shared buffer requests, a request from any upper input beats every lower request.
- R6: Inside the winning tier, the winner is the first requesting source found when the search starts at that tier's pointer and wraps around. The pointer starts at the lowest position of the tier after reset. After a grant in that tier, the pointer moves to the position just after the winner, wrapping to the lowest position.
- R7: A tier's pointer keeps its value when the grant goes to a different tier or no grant is issued.
- R8: While the output is held, changes on the request lines have no effect, and `grant` stays on the same owner.
- R9: A trailer bit from the owner frees the output in the next cycle. Trailer bits from sources that are not the owner, and trailer bits seen while the output is free, have no effect.
- R10: If requests are present when the owner's trailer arrives, the output is free for exactly one cycle and a new grant appears in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N_SHR+N_UP+N_DOWN | One request line per source, packed in tier order |
| trailer | input | N_SHR+N_UP+N_DOWN | High while that source's trailer flit passes |
| grant | output | N_SHR+N_UP+N_DOWN | One-hot owner of the output, all zero when free |
| busy | output | 1 | Output is held by a packet |

## Verification
Every one of the 1024 request patterns of the default ten-source configuration is applied to a free output, in increasing order. The expected winner comes from an arithmetic model that keeps its own three pointers, so the sweep shows both the tier ranking and whether each tier's pointer moves only on its own grants. During each held packet, the bench inverts the request pattern and raises trailer bits on every other source, which shows whether the hold ignores them. An all-ones trailer while the output is free shows whether the release reacts only to the owner. A final case keeps requests present through a release, which shows the single idle cycle before the next grant.

// File: rtl/wh_alloc_pkg.sv
package wh_alloc_pkg;

   localparam int NUM_TIERS = 3;

   // tier order is priority order: index 0 wins over 1, 1 over 2
   typedef enum logic [1:0] {
      TIER_SHARED = 2'd0,
      TIER_UPPER  = 2'd1,
      TIER_LOWER  = 2'd2,
      TIER_NONE   = 2'd3
   } tier_e;

   function automatic int tier_width(input int t, input int ns, input int nu, input int nd);
      case (t)
         0:       return ns;
         1:       return nu;
         default: return nd;
      endcase
   endfunction

   function automatic int tier_base(input int t, input int ns, input int nu);
      case (t)
         0:       return 0;
         1:       return ns;
         default: return ns + nu;
      endcase
   endfunction

   function automatic int ptr_bits(input int w);
      return (w > 1) ? $clog2(w) : 1;
   endfunction

endpackage

// File: rtl/wh_rr_pick.sv
module wh_rr_pick #(
   parameter int W  = 4,
   localparam int PW = wh_alloc_pkg::ptr_bits(W)
) (
   input  logic [W-1:0]  req,
   input  logic [PW-1:0] ptr,
   output logic [W-1:0]  gnt,
   output logic [PW-1:0] idx,
   output logic          any
);

   if (W < 1) begin : g_bad_width
      $error("wh_rr_pick: W must be at least 1");
   end

   // search from ptr upward, wrapping once
   always_comb begin
      logic found;
      found = 1'b0;
      gnt   = '0;
      idx   = '0;
      for (int i = 0; i < W; i++) begin
         int pos;
         logic [PW-1:0] pos_w;
         pos = int'(ptr) + i;
         if (pos >= W) pos = pos - W;
         pos_w = PW'(pos);
         if (!found && req[pos_w]) begin
            found      = 1'b1;
            gnt[pos_w] = 1'b1;
            idx        = pos_w;
         end
      end
   end

   assign any = |req;

endmodule

// File: rtl/wh_rr_ptr.sv
module wh_rr_ptr #(
   parameter int W  = 4,
   localparam int PW = wh_alloc_pkg::ptr_bits(W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  logic [PW-1:0] win_idx,
   output logic [PW-1:0] ptr
);

   localparam logic [PW-1:0] LAST = PW'(W - 1);

   logic [PW-1:0] ptr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (adv) begin
         ptr_q <= (win_idx == LAST) ? '0 : win_idx + PW'(1);
      end
   end

   assign ptr = ptr_q;

   // R7
   ptr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(ptr_q));

   // R6
   ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(ptr_q) < W);

endmodule

// File: rtl/wh_hold_ctrl.sv
module wh_hold_ctrl #(
   parameter int N = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   input  logic [N-1:0] trailer,
   input  logic [N-1:0] win,
   output logic         launch,
   output logic [N-1:0] grant,
   output logic         busy
);

   logic [N-1:0] own_q;
   logic         held;
   logic         owner_tail;

   assign held       = |own_q;
   assign owner_tail = |(own_q & trailer);
   assign launch     = !held && (|req);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         own_q <= '0;
      end else if (held) begin
         if (owner_tail) own_q <= '0;
      end else if (launch) begin
         own_q <= win;
      end
   end

   assign grant = own_q;
   assign busy  = held;

   // R3
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(own_q));

   // R3
   grant_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> busy && (|(own_q & $past(req))));

   // R2
   idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!held && !(|req)) |=> !busy);

   // R8
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (held && !owner_tail) |=> $stable(own_q));

   // R9
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (held && owner_tail) |=> !busy);

endmodule

// File: rtl/wh_out_alloc.sv
module wh_out_alloc #(
   parameter int N_SHR  = 2,
   parameter int N_UP   = 4,
   parameter int N_DOWN = 4,
   localparam int N_SRC = N_SHR + N_UP + N_DOWN
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] req,
   input  logic [N_SRC-1:0] trailer,
   output logic [N_SRC-1:0] grant,
   output logic             busy
);

   import wh_alloc_pkg::*;

   localparam logic [N_SRC-1:0] SHR_MASK = N_SRC'((1 << N_SHR) - 1);
   localparam logic [N_SRC-1:0] UP_MASK  = N_SRC'(((1 << N_UP) - 1) << N_SHR);

   if (N_SHR < 1 || N_UP < 1 || N_DOWN < 1) begin : g_bad_tiers
      $error("wh_out_alloc: every tier needs at least one source");
   end
   if (N_SRC > 30) begin : g_bad_total
      $error("wh_out_alloc: too many sources for the tier masks");
   end

   logic [NUM_TIERS-1:0] tier_any;
   logic [NUM_TIERS-1:0] tier_win;
   logic [N_SRC-1:0]     tier_vec [NUM_TIERS];
   logic [N_SRC-1:0]     win;
   logic                 launch;

   for (genvar t = 0; t < NUM_TIERS; t++) begin : g_tier
      localparam int W   = tier_width(t, N_SHR, N_UP, N_DOWN);
      localparam int OFF = tier_base(t, N_SHR, N_UP);
      localparam int PW  = ptr_bits(W);

      logic [W-1:0]  gnt;
      logic [PW-1:0] idx;
      logic [PW-1:0] ptr;

      wh_rr_pick #(.W(W)) u_pick (
         .req (req[OFF +: W]),
         .ptr (ptr),
         .gnt (gnt),
         .idx (idx),
         .any (tier_any[t])
      );

      wh_rr_ptr #(.W(W)) u_ptr (
         .clk     (clk),
         .rst_n   (rst_n),
         .adv     (launch && tier_win[t]),
         .win_idx (idx),
         .ptr     (ptr)
      );

      assign tier_vec[t] = N_SRC'(gnt) << OFF;
   end

   // fixed ranking between tiers
   assign tier_win[0] = tier_any[0];
   assign tier_win[1] = tier_any[1] && !tier_any[0];
   assign tier_win[2] = tier_any[2] && !tier_any[1] && !tier_any[0];

   always_comb begin
      win = '0;
      for (int t = 0; t < NUM_TIERS; t++) begin
         if (tier_win[t]) win = tier_vec[t];
      end
   end

   wh_hold_ctrl #(.N(N_SRC)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req),
      .trailer (trailer),
      .win     (win),
      .launch  (launch),
      .grant   (grant),
      .busy    (busy)
   );

   // R4
   shared_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && (|(req & SHR_MASK))) |=> (|(grant & SHR_MASK)));

   // R5
   upper_over_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !(|(req & SHR_MASK)) && (|(req & UP_MASK))) |=> (|(grant & UP_MASK)));

endmodule

// File: tb/wh_out_alloc_test.sv
`timescale 1ns/1ps
module wh_out_alloc_test;

   localparam int NS = 2, NU = 4, ND = 4;
   localparam int N  = NS + NU + ND;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] req = '0;
   logic [N-1:0] trl = '0;
   logic [N-1:0] grant;
   logic         busy;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   int ptr_m [3];

   always #5 clk = ~clk;

   wh_out_alloc #(.N_SHR(NS), .N_UP(NU), .N_DOWN(ND)) uut (
      .clk(clk), .rst_n(rst_n), .req(req), .trailer(trl),
      .grant(grant), .busy(busy)
   );

   task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: grant=%b expected %b", tag, act, exp);
      end
   endtask

   task automatic chk_busy(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: busy=%b expected %b", tag, act, exp);
      end
   endtask

   // model: tier ranking, then rotating search from the tier pointer
   task automatic arbitrate(input logic [N-1:0] p, output logic [N-1:0] e);
      int offs [3];
      int wid  [3];
      offs = '{0, NS, NS + NU};
      wid  = '{NS, NU, ND};
      e = '0;
      for (int t = 0; t < 3; t++) begin
         if (e == '0) begin
            for (int i = 0; i < wid[t]; i++) begin
               int pos;
               pos = (ptr_m[t] + i) % wid[t];
               if (e == '0 && p[offs[t] + pos]) begin
                  e = N'(1) << (offs[t] + pos);
                  ptr_m[t] = (pos + 1) % wid[t];
               end
            end
         end
      end
   endtask

   function automatic string tier_tag(input logic [N-1:0] p);
      if (p == '0) return "R2";
      if (|p[NS-1:0]) return "R3 R4 R6 R7";
      if (|p[NS+NU-1:NS]) return "R3 R5 R6 R7";
      return "R3 R6 R7";
   endfunction

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [N-1:0] e;
      logic [N-1:0] e2;
      ptr_m = '{0, 0, 0};
      repeat (3) @(negedge clk);
      // R1
      chk("R1", grant, '0);
      chk_busy("R1", busy, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int p = 0; p < (1 << N); p++) begin
         req = N'(p);
         trl = '0;
         @(negedge clk);
         arbitrate(N'(p), e);
         chk(tier_tag(N'(p)), grant, e);
         chk_busy(tier_tag(N'(p)), busy, (p != 0));
         if (p != 0) begin
            // R8: inverted requests and foreign trailers during the hold
            req = ~N'(p);
            trl = ~e;
            @(negedge clk);
            chk("R8 R9", grant, e);
            // R9: owner trailer frees the output
            req = '0;
            trl = '1;
            @(negedge clk);
            chk("R9", grant, '0);
            chk_busy("R9", busy, 1'b0);
            // R9: trailer while free is ignored
            trl = '1;
            @(negedge clk);
            chk("R9", grant, '0);
         end
      end

      // R10: requests held across the release
      req = '1;
      trl = '0;
      @(negedge clk);
      arbitrate('1, e);
      chk("R10", grant, e);
      trl = e;
      @(negedge clk);
      chk("R10", grant, '0);
      chk_busy("R10", busy, 1'b0);
      trl = '0;
      @(negedge clk);
      arbitrate('1, e2);
      chk("R10", grant, e2);
      chk_busy("R10", busy, 1'b1);
      req = '0;
      trl = e2;
      @(negedge clk);
      chk("R9", grant, '0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule